// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block sits after the decoder of a two-way in-order core and decides, cycle by cycle, how many of the two oldest decoded instructions leave decode. Slot A holds the older instruction and slot B the younger one. Each slot is tagged with an issue group. A fixed conflict matrix over the groups decides whether B may issue alongside A. When pairing is refused, only A issues. The surrounding queue then presents B as the new A in the next cycle, so program order is kept.

Serializing instructions hold both decode slots. Some of them also carry a count of extra cycles for which decode stays locked. Examples are a far branch or return (1 extra cycle, 2 in total), a return from exception (4 extra, 5 in total) and a call (15 extra, 16 in total). While such a lock counts down, the block raises a stall and issues nothing. Data hazards, forwarding and the execution units are outside this block.

Top module: `pair_issue`

## Requirements
- R1: When not in reset and not stalled, issueA equals aValid. issueB is never high unless issueA is high in the same cycle.
- R2: issueB stays low when bValid is low or when aValid is low.
- R3: The group codes are simple-move 0, integer 1, branch 2, memory 3, float 4 and serializing 5. Codes 6 and 7 are handled as serializing. A serializing code in either slot prevents pairing.
- R4: The pairs integer+integer, integer+branch (in either order) and branch+branch never issue together.
- R5: The pairs branch+memory (in either order) and memory+memory never issue together.
- R6: The pair float+float never issues together.
- R7: Simple-move (code 0) pairs with every non-serializing code. The pairs integer+memory, integer+float, branch+float and memory+float pair in either order.
- R8: When slot A issues with a serializing code and an extra count N>0, stall is high for exactly the N following cycles, and both issue outputs stay low during those cycles. Issue resumes in the cycle after them.
- R9: The extra count has no effect when A is not serializing, and none when A is not valid.
- R10: A synchronous active-high reset clears any pending lock. While reset is high, nothing issues.
- R11: A serializing instruction with an extra count of 0 issues alone and raises no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| aValid | input | 1 | Older slot holds an instruction |
| aGroup | input | 3 | Issue group code of the older instruction |
| aLock | input | LOCK_W | Extra decode-lock cycles of the older instruction |
| bValid | input | 1 | Younger slot holds an instruction |
| bGroup | input | 3 | Issue group code of the younger instruction |
| issueA | output | 1 | Older instruction issues this cycle |
| issueB | output | 1 | Younger instruction issues alongside it |
| stall | output | 1 | Decode is locked by an earlier serializing instruction |

## Verification
The bench builds the block with the default LOCK_W of 5, so the extra count can reach 31. This width covers the 15-cycle call lock with room to spare. The 3-bit group field lets the bench sweep all 64 group pairs, including the two unused codes. With the default width, the bench can also interrupt a long call lock with reset and check that the lock does not carry over.

// File: rtl/pair_pkg.sv
package pair_pkg;
  localparam int GRP_W = 3;

  typedef enum logic [GRP_W-1:0] {
    GRP_MOVE = 3'd0,
    GRP_INT  = 3'd1,
    GRP_BRA  = 3'd2,
    GRP_MEM  = 3'd3,
    GRP_FLT  = 3'd4,
    GRP_SER  = 3'd5
  } grp_e;

  typedef struct packed {
    logic load;
    logic dec;
  } lock_ctl_t;

  function automatic logic isSerial(input logic [GRP_W-1:0] g);
    return g >= GRP_SER;
  endfunction

  function automatic logic canPair(input logic [GRP_W-1:0] x, input logic [GRP_W-1:0] y);
    logic ok;
    if (isSerial(x) || isSerial(y))               ok = 1'b0;
    else if (x == GRP_MOVE || y == GRP_MOVE)      ok = 1'b1;
    else if (x == y)                              ok = 1'b0;
    else if ((x == GRP_INT && y == GRP_BRA) || (x == GRP_BRA && y == GRP_INT)) ok = 1'b0;
    else if ((x == GRP_BRA && y == GRP_MEM) || (x == GRP_MEM && y == GRP_BRA)) ok = 1'b0;
    else                                          ok = 1'b1;
    return ok;
  endfunction
endpackage

// File: rtl/pair_lock_dp.sv
module pair_lock_dp
  import pair_pkg::*;
#(
  parameter int LOCK_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  lock_ctl_t         ctl,
  input  logic [LOCK_W-1:0] loadVal,
  output logic              lockBusy
);
  logic [LOCK_W-1:0] lockCnt;

  always_ff @(posedge clk) begin
    if (rst)           lockCnt <= '0;
    else if (ctl.load) lockCnt <= loadVal;
    else if (ctl.dec)  lockCnt <= lockCnt - LOCK_W'(1);
  end

  assign lockBusy = (lockCnt != '0);
endmodule

// File: rtl/pair_ctrl.sv
module pair_ctrl
  import pair_pkg::*;
#(
  parameter int LOCK_W = 5
) (
  input  logic              rst,
  input  logic              aValid,
  input  logic [GRP_W-1:0]  aGroup,
  input  logic [LOCK_W-1:0] aLock,
  input  logic              bValid,
  input  logic [GRP_W-1:0]  bGroup,
  input  logic              lockBusy,
  output logic              issueA,
  output logic              issueB,
  output lock_ctl_t         ctl
);
  logic open;

  always_comb begin
    open     = !rst && !lockBusy;
    issueA   = open && aValid;
    issueB   = issueA && bValid && canPair(aGroup, bGroup);
    ctl.load = issueA && isSerial(aGroup) && (aLock != '0);
    ctl.dec  = !rst && lockBusy;
  end
endmodule

// File: rtl/pair_issue.sv
module pair_issue
  import pair_pkg::*;
#(
  parameter int LOCK_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              aValid,
  input  logic [GRP_W-1:0]  aGroup,
  input  logic [LOCK_W-1:0] aLock,
  input  logic              bValid,
  input  logic [GRP_W-1:0]  bGroup,
  output logic              issueA,
  output logic              issueB,
  output logic              stall
);
  lock_ctl_t ctl;
  logic      lockBusy;

  pair_ctrl #(.LOCK_W(LOCK_W)) uCtrl (
    .rst(rst), .aValid(aValid), .aGroup(aGroup), .aLock(aLock),
    .bValid(bValid), .bGroup(bGroup), .lockBusy(lockBusy),
    .issueA(issueA), .issueB(issueB), .ctl(ctl)
  );

  pair_lock_dp #(.LOCK_W(LOCK_W)) uLock (
    .clk(clk), .rst(rst), .ctl(ctl), .loadVal(aLock), .lockBusy(lockBusy)
  );

  assign stall = lockBusy;
endmodule

// File: rtl/pair_chk.sv
module pair_chk #(
  parameter int LOCK_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              aValid,
  input logic [2:0]        aGroup,
  input logic [LOCK_W-1:0] aLock,
  input logic              bValid,
  input logic [2:0]        bGroup,
  input logic              issueA,
  input logic              issueB,
  input logic              stall
);
  logic [LOCK_W-1:0] expRem;

  always_ff @(posedge clk) begin
    if (rst) expRem <= '0;
    else if (issueA && aGroup >= 3'd5 && aLock != '0) expRem <= aLock;
    else if (expRem != '0) expRem <= expRem - LOCK_W'(1);
  end

  a_r8_lock_length: assert property (@(posedge clk) disable iff (rst)
    stall == (expRem != '0));
  a_r8_quiet_stall: assert property (@(posedge clk) disable iff (rst)
    stall |-> (!issueA && !issueB));
  a_r1_order: assert property (@(posedge clk) disable iff (rst)
    issueB |-> issueA);
  a_r2_valid_pair: assert property (@(posedge clk) disable iff (rst)
    issueB |-> (aValid && bValid));
  a_r3_serial_alone: assert property (@(posedge clk) disable iff (rst)
    issueB |-> (aGroup < 3'd5 && bGroup < 3'd5));
  a_r4_int_bra: assert property (@(posedge clk) disable iff (rst)
    issueB |-> !((aGroup == 3'd1 || aGroup == 3'd2) && (bGroup == 3'd1 || bGroup == 3'd2)));
  a_r6_flt_pair: assert property (@(posedge clk) disable iff (rst)
    issueB |-> !(aGroup == 3'd4 && bGroup == 3'd4));
  a_r9_no_lock: assert property (@(posedge clk) disable iff (rst)
    (issueA && aGroup < 3'd5) |=> !stall);
  a_r10_reset_clear: assert property (@(posedge clk)
    rst |=> !stall);
endmodule

bind pair_issue pair_chk #(.LOCK_W(LOCK_W)) uChk (
  .clk(clk), .rst(rst), .aValid(aValid), .aGroup(aGroup), .aLock(aLock),
  .bValid(bValid), .bGroup(bGroup), .issueA(issueA), .issueB(issueB), .stall(stall)
);

// File: tb/tb_pair_issue.sv
`timescale 1ns/1ps
module tb_pair_issue;
  localparam int LOCK_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic aValid = 1'b0, bValid = 1'b0;
  logic [2:0] aGroup = '0, bGroup = '0;
  logic [LOCK_W-1:0] aLock = '0;
  logic issueA, issueB, stall;

  always #2 clk = ~clk;

  pair_issue #(.LOCK_W(LOCK_W)) dut (
    .clk(clk), .rst(rst), .aValid(aValid), .aGroup(aGroup), .aLock(aLock),
    .bValid(bValid), .bGroup(bGroup), .issueA(issueA), .issueB(issueB), .stall(stall)
  );

  typedef struct {
    logic  ia;
    logic  ib;
    logic  st;
    string tag;
  } exp_t;

  exp_t expQ[$];
  event sampleEv;
  int   checks = 0;
  int   failures = 0;
  int   benchLock = 0;
  bit   done = 1'b0;

  // Pair rules written from the requirements, as a list of refused pairs.
  function automatic bit refPair(input int a, input int b, output string tag);
    if (a >= 5 || b >= 5) begin tag = "R3"; return 0; end
    if (a == 0 || b == 0) begin tag = "R7"; return 1; end
    if ((a == 1 && b == 1) || (a == 1 && b == 2) || (a == 2 && b == 1) || (a == 2 && b == 2)) begin
      tag = "R4"; return 0;
    end
    if ((a == 2 && b == 3) || (a == 3 && b == 2) || (a == 3 && b == 3)) begin
      tag = "R5"; return 0;
    end
    if (a == 4 && b == 4) begin tag = "R6"; return 0; end
    tag = "R7";
    return 1;
  endfunction

  task automatic step(input logic av, input int ag, input int al,
                      input logic bv, input int bg, input string tagIn);
    exp_t  e;
    string pt;
    bit    ok;
    @(negedge clk);
    rst = 1'b0;
    aValid = av; aGroup = 3'(ag); aLock = LOCK_W'(al);
    bValid = bv; bGroup = 3'(bg);
    #1;
    ok = refPair(ag, bg, pt);
    e.tag = tagIn;
    if (benchLock > 0) begin
      e.ia = 1'b0; e.ib = 1'b0; e.st = 1'b1;
      benchLock = benchLock - 1;
    end else begin
      e.ia = av;
      e.ib = av && bv && ok;
      e.st = 1'b0;
      if (av && ag >= 5 && al != 0) benchLock = al;
    end
    expQ.push_back(e);
    -> sampleEv;
  endtask

  task automatic doReset(input string tagIn);
    exp_t e;
    @(negedge clk);
    rst = 1'b1;
    aValid = 1'b1; aGroup = 3'd0; bValid = 1'b1; bGroup = 3'd0; aLock = '0;
    @(posedge clk);
    #1;
    e.ia = 1'b0; e.ib = 1'b0; e.st = 1'b0; e.tag = tagIn;
    benchLock = 0;
    expQ.push_back(e);
    -> sampleEv;
  endtask

  // Monitor: pop the expected item and compare against the ports.
  initial begin
    exp_t e;
    forever begin
      @(sampleEv);
      e = expQ.pop_front();
      checks++;
      if (issueA !== e.ia || issueB !== e.ib || stall !== e.st) begin
        failures++;
        $display("FAIL %s: issueA/issueB/stall actual=%b%b%b expected=%b%b%b",
                 e.tag, issueA, issueB, stall, e.ia, e.ib, e.st);
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    string t;
    doReset("R10 reset state");
    step(1'b1, 0, 0, 1'b1, 0, "R11 idle after reset");
    // Full sweep of the group-pair matrix, including codes 6 and 7
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        void'(refPair(a, b, t));
        step(1'b1, a, 0, 1'b1, b, t);
      end
    end
    // R2: invalid slots
    step(1'b1, 0, 0, 1'b0, 0, "R2 b invalid");
    step(1'b0, 0, 0, 1'b1, 0, "R2 a invalid");
    step(1'b0, 3, 0, 1'b0, 1, "R1 nothing valid");
    // R8: far-branch style lock, 1 extra cycle
    step(1'b1, 5, 1, 1'b1, 0, "R8 lock1 issue");
    step(1'b1, 1, 0, 1'b1, 3, "R8 lock1 stall");
    step(1'b1, 1, 0, 1'b1, 3, "R8 lock1 resume");
    // R8: exception-return style lock, 4 extra cycles
    step(1'b1, 5, 4, 1'b1, 1, "R8 lock4 issue");
    for (int i = 0; i < 4; i++) step(1'b1, 0, 0, 1'b1, 4, "R8 lock4 stall");
    step(1'b1, 0, 0, 1'b1, 4, "R8 lock4 resume");
    // R8: call style lock, 15 extra cycles, code 7 also locks
    step(1'b1, 7, 15, 1'b0, 0, "R8 lock15 issue");
    for (int i = 0; i < 15; i++) step(1'b1, 2, 0, 1'b1, 4, "R8 lock15 stall");
    step(1'b1, 2, 0, 1'b1, 4, "R8 lock15 resume");
    // R11: serializing with zero extra count
    step(1'b1, 5, 0, 1'b1, 0, "R11 zero count");
    step(1'b1, 0, 0, 1'b1, 1, "R11 no stall after");
    // R9: count ignored for non-serializing and invalid A
    step(1'b1, 1, 7, 1'b1, 3, "R9 int with count");
    step(1'b1, 3, 0, 1'b1, 4, "R9 no stall after int");
    step(1'b0, 5, 5, 1'b1, 0, "R9 invalid serializing");
    step(1'b1, 4, 0, 1'b1, 0, "R9 no stall after invalid");
    // R10: reset during a long lock
    step(1'b1, 5, 15, 1'b0, 0, "R10 lock start");
    for (int i = 0; i < 3; i++) step(1'b1, 0, 0, 1'b0, 0, "R10 stall before reset");
    doReset("R10 reset mid lock");
    step(1'b1, 1, 0, 1'b1, 4, "R10 lock cleared");
    step(1'b1, 2, 0, 1'b1, 2, "R4 bra pair after reset");
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule